// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. The capacitor DAC, the sampling switch and the comparator sit outside the block. The block drives the trial code into the DAC and the switch enable. It reads back the comparator's decision and builds the result one bit per cycle, starting at the most significant bit.

A single write to the control register starts a burst of four back-to-back conversions. The write also carries a channel number, which the block holds on an output for the analog multiplexer. Each conversion has three parts: a fixed twelve-cycle sample window with the switch closed, eight trial cycles, and one store cycle. The four results land in four separate result slots, in order. After the fourth store, a completion flag rises and stays up until the next control write.

A control write that arrives while a burst is running abandons that burst. The new burst starts again from the first slot. Slots the abandoned burst did not reach keep their earlier contents. The CPU reads any slot at any time by its index.

Top module: `adc_sar_sequencer`

## Requirements
- R1: After reset, `done` and `sample_en` are 0, `dac_code` is 0, `chan_sel` is 0 and every result slot reads 0; without a control write the block stays idle.
- R2: The clock edge that samples `ctl_wr` high starts a sample window: `sample_en` is 1 for exactly 12 cycles beginning in the following cycle, and likewise for each conversion of the burst.
- R3: The first trial cycle after each sample window presents `dac_code` with only bit 7 set (8'h80); trials then walk down one bit per cycle to bit 0.
- R4: In each trial, `cmp_in` = 1 (analog input at or above the trial level) keeps the bit under test and `cmp_in` = 0 clears it. With an ideal comparator, the stored result equals the input level, including 8'h00 and 8'hFF.
- R5: The four conversions of a burst are stored in slots 0, 1, 2 and 3 in that order. `rd_data` shows the slot selected by `rd_slot`.
- R6: Each conversion lasts 21 cycles (12 sample, 8 trial, 1 store). `dac_code` is 0 whenever `sample_en` is 1.
- R7: `done` rises exactly 84 cycles after the write edge, i.e. after the fourth store. It holds until a control write, and is 0 in the cycle after any control write.
- R8: A control write during a burst aborts it. The new burst fills slot 0 first, and slots the aborted burst did not reach keep their old values.
- R9: `chan_sel` takes the value of `ctl_chan` at the control write and holds it until the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-register write strobe; starts or restarts a burst |
| ctl_chan | input | CHAN_W | Channel number carried by the control write |
| rd_slot | input | SLOT_W | Result slot index for CPU reads |
| rd_data | output | DATA_W | Contents of the selected result slot |
| dac_code | output | DATA_W | Trial code driven to the capacitor DAC |
| sample_en | output | 1 | Closes the analog sample switch |
| cmp_in | input | 1 | Comparator decision: 1 when input is at or above the DAC level |
| chan_sel | output | CHAN_W | Latched channel number for the analog multiplexer |
| done | output | 1 | Burst complete: all four slots written |

## Verification
The bench models an ideal comparator against a chosen level per conversion. It targets the range ends 8'h00 and 8'hFF and alternating bit patterns. A trial that tested bits in the wrong order, or inverted the comparator sense, would store the wrong code. A sample window off by one cycle, or a sample that overlapped the first trial, would show up in the per-cycle count of `sample_en` and in the 8'h80 check. The bench checks `done` one cycle before and exactly at the 84th edge, to catch a flag that rises one store early or late. An abort test restarts a burst in its second conversion. A design that kept filling from the old slot index, or that let the abandoned burst still raise `done`, would put data in the wrong slot.

// File: rtl/sar_seq_pkg.sv
// Shared types for the successive-approximation sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package sar_seq_pkg;

    // Phase of the conversion burst
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_STORE  = 2'd3
    } phase_t;

endpackage

// File: rtl/sar_sample_timer.sv
// Counts the cycles of the sample window and flags the final one.
// Assumes: run is high for the whole window and restart is a one-cycle
// pulse that abandons any partial count; SAMPLE_CYC is at least 2.
module sar_sample_timer #(
    parameter int SAMPLE_CYC = 12,
    localparam int CNT_W = $clog2(SAMPLE_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic last
);

    logic [CNT_W-1:0] cnt;

    // Count up while sampling; clear when idle or on a restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run || last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Final cycle of the window
    always_comb begin
        last = run && (cnt == CNT_W'(SAMPLE_CYC - 1));
    end

endmodule

// File: rtl/sar_bit_engine.sv
// Successive-approximation register with a one-hot probe marking the bit
// under test. Each trial cycle shows the kept bits plus the probe bit on
// the DAC, then keeps or drops the probe bit from the comparator.
// Assumes: clear is held during sampling so every conversion starts from
// zero with the probe on the most significant bit.
module sar_bit_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              trial,
    input  logic              cmp_in,
    output logic [DATA_W-1:0] dac_code,
    output logic [DATA_W-1:0] value,
    output logic              trial_last
);

    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] kept;
    logic [DATA_W-1:0] probe;

    // Update the kept bits and walk the probe toward the LSB
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kept  <= '0;
            probe <= MSB_ONLY;
        end else if (clear) begin
            kept  <= '0;
            probe <= MSB_ONLY;
        end else if (trial) begin
            if (cmp_in) begin
                kept <= kept | probe;
            end
            probe <= probe >> 1;
        end
    end

    // Trial level and end-of-trials marker
    always_comb begin
        dac_code   = trial ? (kept | probe) : '0;
        value      = kept;
        trial_last = trial && probe[0];
    end

endmodule

// File: rtl/sar_result_bank.sv
// Holds one result per slot; a store writes the addressed slot only.
// Assumes: at most one store per cycle; reads are combinational.
module sar_result_bank #(
    parameter int DATA_W    = 8,
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_SLOTS*DATA_W-1:0] flat;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic [DATA_W-1:0] q;

        // Capture the result when this slot is addressed
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                q <= wr_data;
            end
        end

        assign flat[g*DATA_W +: DATA_W] = q;
    end

    // Read multiplexer
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_slot == SLOT_W'(i)) begin
                rd_data = flat[i*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/adc_sar_sequencer.sv
// Top of the successive-approximation sequencer. A control write latches
// the channel, clears the completion flag and starts a burst of
// NUM_SLOTS conversions; each one is a sample window, DATA_W trials and
// one store into the next slot.
// Assumes: external DAC settles and comparator resolves within one cycle;
// NUM_SLOTS is at least 2; a write always wins over the running burst.
module adc_sar_sequencer
    import sar_seq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_CYC = 12,
    parameter int NUM_SLOTS  = 4,
    parameter int CHAN_W     = 3,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CHAN_W-1:0] ctl_chan,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dac_code,
    output logic              sample_en,
    input  logic              cmp_in,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              done
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    phase_t            phase;
    logic [SLOT_W-1:0] slot;
    logic              samp_last;
    logic              trial_last;
    logic              store_en;
    logic              engine_clear;
    logic [DATA_W-1:0] sar_value;

    // Phase sequencing, slot pointer, flag and channel latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            slot     <= '0;
            done     <= 1'b0;
            chan_sel <= '0;
        end else if (ctl_wr) begin
            phase    <= PH_SAMPLE;
            slot     <= '0;
            done     <= 1'b0;
            chan_sel <= ctl_chan;
        end else begin
            unique case (phase)
                PH_SAMPLE: if (samp_last)  phase <= PH_TRIAL;
                PH_TRIAL:  if (trial_last) phase <= PH_STORE;
                PH_STORE: begin
                    if (slot == LAST_SLOT) begin
                        phase <= PH_IDLE;
                        slot  <= '0;
                        done  <= 1'b1;
                    end else begin
                        phase <= PH_SAMPLE;
                        slot  <= slot + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Phase-derived controls
    always_comb begin
        sample_en    = (phase == PH_SAMPLE);
        store_en     = (phase == PH_STORE) && !ctl_wr;
        engine_clear = ctl_wr || (phase == PH_SAMPLE) || (phase == PH_STORE);
    end

    sar_sample_timer #(
        .SAMPLE_CYC(SAMPLE_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(ctl_wr),
        .run    (sample_en),
        .last   (samp_last)
    );

    sar_bit_engine #(
        .DATA_W(DATA_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (engine_clear),
        .trial     (phase == PH_TRIAL && !ctl_wr),
        .cmp_in    (cmp_in),
        .dac_code  (dac_code),
        .value     (sar_value),
        .trial_last(trial_last)
    );

    sar_result_bank #(
        .DATA_W   (DATA_W),
        .NUM_SLOTS(NUM_SLOTS)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (store_en),
        .wr_slot(slot),
        .wr_data(sar_value),
        .rd_slot(rd_slot),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/adc_sar_sequencer_chk.sv
// Port-level checker for the sequencer, bound to every instance.
// Assumes: synchronous active-low reset held from time zero.
module adc_sar_sequencer_chk #(
    parameter int DATA_W     = 8,
    parameter int SAMPLE_CYC = 12,
    parameter int CHAN_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic [DATA_W-1:0] dac_code,
    input logic              sample_en,
    input logic [CHAN_W-1:0] chan_sel,
    input logic              done
);

    localparam int RUN_W = $clog2(SAMPLE_CYC + 1) + 1;
    localparam logic [DATA_W-1:0] MSB_ONLY = {1'b1, {(DATA_W-1){1'b0}}};

    logic [RUN_W-1:0] run_cnt;

    // Length of the current sample window so far
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_wr || !sample_en) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_WR_OPENS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |=> sample_en); // R2
    AST_SAMPLE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n) sample_en |-> (run_cnt < RUN_W'(SAMPLE_CYC))); // R2
    AST_FIRST_TRIAL_MSB: assert property (@(posedge clk) disable iff (!rst_n) $fell(sample_en) |-> (dac_code == MSB_ONLY)); // R3
    AST_SAMPLE_DAC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) sample_en |-> (dac_code == '0)); // R6
    AST_WR_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n) ctl_wr |=> !done); // R7
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (done && !ctl_wr) |=> done); // R7
    AST_DONE_NOT_SAMPLING: assert property (@(posedge clk) disable iff (!rst_n) done |-> !sample_en); // R7
    AST_CHAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !ctl_wr |=> $stable(chan_sel)); // R9

endmodule

bind adc_sar_sequencer adc_sar_sequencer_chk #(
    .DATA_W    (DATA_W),
    .SAMPLE_CYC(SAMPLE_CYC),
    .CHAN_W    (CHAN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (ctl_wr),
    .dac_code (dac_code),
    .sample_en(sample_en),
    .chan_sel (chan_sel),
    .done     (done)
);

// File: tb/adc_sar_sequencer_bench.sv
module adc_sar_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CONV_CYC   = 21;
    localparam int NUM_ROWS   = 4;
    // Each row: four input levels, first conversion in the top byte
    localparam logic [31:0] VEC [NUM_ROWS] = '{
        32'h00_FF_80_7F,
        32'h55_AA_01_FE,
        32'h3C_C3_10_EF,
        32'h12_34_56_78
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr;
    logic [2:0] ctl_chan;
    logic [1:0] rd_slot;
    logic [7:0] rd_data;
    logic [7:0] dac_code;
    logic       sample_en;
    logic       cmp_in;
    logic [2:0] chan_sel;
    logic       done;
    logic [7:0] vin;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ideal comparator
    assign cmp_in = (vin >= dac_code);

    adc_sar_sequencer u_adc_sar_sequencer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_wr   (ctl_wr),
        .ctl_chan (ctl_chan),
        .rd_slot  (rd_slot),
        .rd_data  (rd_data),
        .dac_code (dac_code),
        .sample_en(sample_en),
        .cmp_in   (cmp_in),
        .chan_sel (chan_sel),
        .done     (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [2:0] ch);
        @(negedge clk);
        ctl_wr   = 1'b1;
        ctl_chan = ch;
        @(negedge clk);
        ctl_wr   = 1'b0;
    endtask

    task automatic read_slot(input int s, input string req, input logic [7:0] exp);
        rd_slot = 2'(s);
        #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    // Runs one full burst from a write, checking timing on the way
    task automatic run_burst(input logic [2:0] ch, input logic [31:0] vals);
        ctl_write(ch);
        for (int k = 0; k < 4; k++) begin
            int  samp = 0;
            bit  dac_bad = 1'b0;
            vin = vals[31-8*k -: 8];
            for (int i = 0; i < CONV_CYC; i++) begin
                if (sample_en) begin
                    samp++;
                    if (dac_code != 8'h00) dac_bad = 1'b1;
                end
                if (i == 12) check(dac_code == 8'h80, "R3 first trial MSB", dac_code, 8'h80);
                if (k == 3 && i == 20) check(done == 1'b0, "R7 done not early", done, 0);
                @(negedge clk);
            end
            check(samp == 12, "R2 sample window length", samp, 12);
            check(!dac_bad, "R6 dac quiet in sample", dac_bad, 0);
        end
        check(done == 1'b1, "R7 done at edge 84", done, 1);
        check(chan_sel == ch, "R9 channel latched", chan_sel, ch);
        for (int k = 0; k < 4; k++) begin
            read_slot(k, "R4 R5 slot result", vals[31-8*k -: 8]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        ctl_wr   = 1'b0;
        ctl_chan = '0;
        rd_slot  = '0;
        vin      = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset and idle state
        check(done == 1'b0, "R1 done after reset", done, 0);
        check(sample_en == 1'b0, "R1 idle without write", sample_en, 0);
        check(dac_code == 8'h00, "R1 dac after reset", dac_code, 0);
        check(chan_sel == 3'd0, "R1 chan after reset", chan_sel, 0);
        for (int s = 0; s < 4; s++) read_slot(s, "R1 slot after reset", 8'h00);

        // Vector table
        for (int r = 0; r < NUM_ROWS; r++) begin
            run_burst(3'(r + 2), VEC[r]);
        end

        // R7 flag holds while idle, then clears on write
        repeat (10) @(negedge clk);
        check(done == 1'b1, "R7 done holds", done, 1);
        ctl_write(3'd1);
        check(done == 1'b0, "R7 write clears done", done, 0);
        check(sample_en == 1'b1, "R2 sample after write", sample_en, 1);

        // Complete a known burst X, then abort a burst Y in its second conversion
        run_burst(3'd6, 32'hA1_B2_C3_D4);
        ctl_write(3'd2);
        vin = 8'h11;
        repeat (30) @(negedge clk);
        ctl_write(3'd5);
        vin = 8'h99;
        check(done == 1'b0, "R8 abort keeps done low", done, 0);
        repeat (CONV_CYC) @(negedge clk);
        read_slot(0, "R8 restart fills slot 0", 8'h99);
        read_slot(1, "R8 unreached slot kept", 8'hB2);
        vin = 8'h44;
        repeat (CONV_CYC) @(negedge clk);
        vin = 8'hEE;
        repeat (CONV_CYC) @(negedge clk);
        vin = 8'h07;
        repeat (CONV_CYC - 1) @(negedge clk);
        check(done == 1'b0, "R8 R7 done not early after abort", done, 0);
        @(negedge clk);
        check(done == 1'b1, "R8 R7 done after restarted burst", done, 1);
        check(chan_sel == 3'd5, "R9 channel of latest write", chan_sel, 5);
        read_slot(1, "R8 slot 1 after restart", 8'h44);
        read_slot(2, "R8 slot 2 after restart", 8'hEE);
        read_slot(3, "R8 slot 3 after restart", 8'h07);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule